// File: doc/BRIEF.md
# Multichannel DAC SPI command engine

This block turns host requests into 24-bit serial command frames for a multi-channel DAC on an SPI link. A request names an operation, a channel, a 16-bit value and a read selector. The block builds the frame, shifts it out MSB first with the clock idling low, and raises chip select when the frame ends. It also takes back register contents from the DAC and pulses the active-low load line that moves staged channel values to the outputs.

A readback takes two frames. The first is a read-request frame. Chip select then stays high for an enforced gap. The second is an all-zero NOP frame, clocked with a slower divider, during which the DAC's reply is shifted in. The low 16 bits of that reply come back on a one-cycle response strobe. Writes to the two global offset DACs are issued as one request that produces two frames in a row, both carrying the same value masked to 14 bits. Converting voltages to codes and doing calibration arithmetic are left to the host.

Top module: `dac_cmd_engine`

## Requirements
- R1: Each frame is 24 bits, MSB first, with cs_no held low for the whole frame and driven high at its end. sclk_o is low whenever cs_no is high. mosi_o changes only on a rising sclk_o edge, and miso_i is sampled on the falling edge.
- R2: Op codes 0, 1 and 2 write a channel's data, offset or gain register. The frame carries command 3, 2 or 1 respectively in bits [23:22], req_chan_i plus 8 in bits [21:16], and req_value_i in bits [15:0].
- R3: Op code 3 writes a special register. The frame carries command 0, special code req_chan_i in bits [21:16] and req_value_i in bits [15:0].
- R4: Op code 4 sends two special frames, first with code 2 and then with code 3. Both carry req_value_i with bits [15:14] cleared. ldac_no stays high throughout.
- R5: Op code 5 sends a read-request frame {2'b00, 6'd5, ((sel + req_chan_i) << 7)[15:0]}, followed by an all-zero NOP frame. The value sel depends on req_sel_i: 0 gives 0x008, 1 gives 0x048, 2 gives 0x088, 3 gives 0x0C8, 4 gives 0x101, 5 gives 0x102, 6 gives 0x103 and 7 gives 0x106.
- R6: Between the read-request frame and the NOP frame, cs_no stays high for at least GAP_CYC clock cycles.
- R7: The sclk_o period is DIV_WR clock cycles for every frame except the readback NOP frame, which uses DIV_RD.
- R8: After the NOP frame, rsp_valid_o is high for exactly one cycle, and rsp_data_o then equals the low 16 bits of the word shifted in on miso_i.
- R9: Op code 6 drives ldac_no low for exactly LDAC_CYC cycles and sends no frame.
- R10: req_ready_o is low from acceptance until the operation completes. A request held valid during that time is not taken.
- R11: Op code 7 is accepted and discarded. It sends no frame and leaves ldac_no high.
- R12: During and after reset, cs_no is high, sclk_o is low, ldac_no is high, req_ready_o is high and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request taken when valid |
| req_op_i | input | 3 | Operation code (see R2 to R11) |
| req_chan_i | input | 6 | Channel number, or special code for op 3 |
| req_value_i | input | 16 | Register value |
| req_sel_i | input | 3 | Readback register selector |
| rsp_valid_o | output | 1 | Readback data strobe |
| rsp_data_o | output | 16 | Readback value |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the DAC |
| miso_i | input | 1 | Serial data from the DAC |
| cs_no | output | 1 | Chip select, active low |
| ldac_no | output | 1 | Output load strobe, active low |

## Verification
The bench models a DAC slave that captures every frame and returns a known word. This catches frames with the wrong command field or a channel missing its bias of 8, and it catches an engine that samples the reply on the wrong edge and so returns shifted data. The readback checks look at the chip-select gap and the slower clock period of the NOP frame. An engine that merged the two frames, or kept the write divider, fails those checks. The offset-pair request must produce exactly two frames with codes 2 then 3 and the top bits cleared. A request held valid while a frame is running must not produce a second frame. The load pulse must last exactly its configured width without starting a frame.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int FRAME_W = 24;

  typedef enum logic [2:0] {
    OP_DATA, OP_OFFSET, OP_GAIN, OP_SPECIAL, OP_OFS_BOTH, OP_READ, OP_LOAD, OP_RSVD
  } op_e;

  localparam logic [5:0] SPC_NOP  = 6'd0;
  localparam logic [5:0] SPC_OFS0 = 6'd2;
  localparam logic [5:0] SPC_OFS1 = 6'd3;
  localparam logic [5:0] SPC_READ = 6'd5;
  localparam logic [5:0] CH_BIAS  = 6'd8;

  function automatic logic [1:0] chan_cmd(op_e op);
    case (op)
      OP_DATA:   return 2'd3;
      OP_OFFSET: return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

  function automatic logic [8:0] rd_sel(logic [2:0] sel);
    case (sel)
      3'd0: return 9'h008;
      3'd1: return 9'h048;
      3'd2: return 9'h088;
      3'd3: return 9'h0C8;
      3'd4: return 9'h101;
      3'd5: return 9'h102;
      3'd6: return 9'h103;
      default: return 9'h106;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] read_frame(logic [2:0] sel, logic [5:0] ch);
    logic [15:0] f;
    f = (16'(rd_sel(sel)) + 16'(ch)) << 7;
    return {2'b00, SPC_READ, f};
  endfunction
endpackage

// File: rtl/dac_half_tick.sv
module dac_half_tick #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] half_i,
  output logic         tick_o
);
  logic [W-1:0] cnt;

  assign tick_o = en_i && (cnt == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (!en_i)  cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dac_spi_shifter.sv
module dac_spi_shifter #(
  parameter int FRAME_W = 24,
  parameter int HALF_W  = 4,
  parameter int RX_W    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [HALF_W-1:0]  half_i,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_no,
  output logic [RX_W-1:0]    rx_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic               busy;
  logic               tick;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   nbit;

  dac_half_tick #(.W(HALF_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy),
    .half_i(half_i),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0; sclk_o <= 1'b0; mosi_o <= 1'b0; cs_no <= 1'b1;
      sh <= '0; rx_o <= '0; nbit <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy <= 1'b1; cs_no <= 1'b0; sclk_o <= 1'b0;
          sh <= frame_i; nbit <= '0;
        end
      end else if (tick) begin
        if (!sclk_o) begin
          // launch edge
          sclk_o <= 1'b1;
          mosi_o <= sh[FRAME_W-1];
          sh     <= {sh[FRAME_W-2:0], 1'b0};
        end else begin
          // capture edge
          sclk_o <= 1'b0;
          rx_o   <= {rx_o[RX_W-2:0], miso_i};
          if (nbit == CNT_W'(FRAME_W-1)) begin
            busy <= 1'b0; cs_no <= 1'b1; done_o <= 1'b1;
          end else begin
            nbit <= nbit + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dac_ldac_pulse.sv
module dac_ldac_pulse #(
  parameter int LOW_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic ldac_no,
  output logic done_o
);
  localparam int CW = $clog2(LOW_CYC + 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0; cnt <= '0; ldac_no <= 1'b1; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active) begin
        if (go_i) begin
          active <= 1'b1; cnt <= '0; ldac_no <= 1'b0;
        end
      end else if (cnt == CW'(LOW_CYC - 1)) begin
        active <= 1'b0; ldac_no <= 1'b1; done_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_cmd_engine.sv
module dac_cmd_engine
  import dac_pkg::*;
#(
  parameter int DIV_WR   = 4,
  parameter int DIV_RD   = 16,
  parameter int GAP_CYC  = 34,
  parameter int LDAC_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [2:0]  req_op_i,
  input  logic [5:0]  req_chan_i,
  input  logic [15:0] req_value_i,
  input  logic [2:0]  req_sel_i,
  output logic        rsp_valid_o,
  output logic [15:0] rsp_data_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no,
  output logic        ldac_no
);
  localparam int DIV_MAX = (DIV_RD > DIV_WR) ? DIV_RD : DIV_WR;
  localparam int HALF_W  = $clog2(DIV_MAX) + 1;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam logic [HALF_W-1:0] HALF_WR = HALF_W'(DIV_WR / 2);
  localparam logic [HALF_W-1:0] HALF_RD = HALF_W'(DIV_RD / 2);

  typedef enum logic [2:0] {
    S_IDLE, S_XFER, S_OFS_A, S_OFS_B, S_RD_REQ, S_RD_GAP, S_RD_NOP, S_LOAD
  } state_e;

  state_e             state;
  logic [FRAME_W-1:0] frame_q;
  logic [HALF_W-1:0]  half_q;
  logic               start_q;
  logic               ldac_go_q;
  logic [GAP_W-1:0]   gap_cnt;
  logic               xfer_done;
  logic               ldac_done;
  logic [15:0]        rx_word;
  op_e                op;

  assign op          = op_e'(req_op_i);
  assign req_ready_o = (state == S_IDLE);

  dac_spi_shifter #(.FRAME_W(FRAME_W), .HALF_W(HALF_W), .RX_W(16)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_q),
    .frame_i(frame_q),
    .half_i (half_q),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .cs_no  (cs_no),
    .rx_o   (rx_word),
    .done_o (xfer_done)
  );

  dac_ldac_pulse #(.LOW_CYC(LDAC_CYC)) u_ldac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (ldac_go_q),
    .ldac_no(ldac_no),
    .done_o (ldac_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE; frame_q <= '0; half_q <= HALF_WR; start_q <= 1'b0;
      ldac_go_q <= 1'b0; gap_cnt <= '0; rsp_valid_o <= 1'b0; rsp_data_o <= '0;
    end else begin
      start_q     <= 1'b0;
      ldac_go_q   <= 1'b0;
      rsp_valid_o <= 1'b0;
      case (state)
        S_IDLE: if (req_valid_i) begin
          half_q <= HALF_WR;
          case (op)
            OP_DATA, OP_OFFSET, OP_GAIN: begin
              frame_q <= {chan_cmd(op), req_chan_i + CH_BIAS, req_value_i};
              start_q <= 1'b1; state <= S_XFER;
            end
            OP_SPECIAL: begin
              frame_q <= {2'b00, req_chan_i, req_value_i};
              start_q <= 1'b1; state <= S_XFER;
            end
            OP_OFS_BOTH: begin
              frame_q <= {2'b00, SPC_OFS0, 2'b00, req_value_i[13:0]};
              start_q <= 1'b1; state <= S_OFS_A;
            end
            OP_READ: begin
              frame_q <= read_frame(req_sel_i, req_chan_i);
              start_q <= 1'b1; state <= S_RD_REQ;
            end
            OP_LOAD: begin
              ldac_go_q <= 1'b1; state <= S_LOAD;
            end
            default: state <= S_IDLE;
          endcase
        end
        S_XFER:  if (xfer_done) state <= S_IDLE;
        S_OFS_A: if (xfer_done) begin
          frame_q <= {frame_q[23:22], SPC_OFS1, frame_q[15:0]};
          start_q <= 1'b1; state <= S_OFS_B;
        end
        S_OFS_B: if (xfer_done) state <= S_IDLE;
        S_RD_REQ: if (xfer_done) begin
          gap_cnt <= '0; state <= S_RD_GAP;
        end
        S_RD_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            frame_q <= {2'b00, SPC_NOP, 16'h0000};
            half_q  <= HALF_RD;
            start_q <= 1'b1; state <= S_RD_NOP;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_RD_NOP: if (xfer_done) begin
          rsp_valid_o <= 1'b1; rsp_data_o <= rx_word; state <= S_IDLE;
        end
        S_LOAD: if (ldac_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_cmd_engine_sva.sv
module dac_cmd_engine_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_no,
  input logic ldac_no
);
  a_r1_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  a_r1_mosi_hold_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(mosi_o));

  a_r10_no_ready_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);

  a_r8_rsp_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r9_ldac_outside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldac_no |-> cs_no);
endmodule

bind dac_cmd_engine dac_cmd_engine_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no),
  .ldac_no    (ldac_no)
);

// File: tb/dac_cmd_engine_test.sv
`timescale 1ns/1ps
module dac_cmd_engine_test;
  localparam int DIV_WR = 4, DIV_RD = 16, GAP_CYC = 34, LDAC_CYC = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0, req_sel = '0;
  logic [5:0] req_chan = '0;
  logic [15:0] req_value = '0;
  logic rsp_valid;
  logic [15:0] rsp_data;
  logic sclk, mosi, cs_n, ldac_n;
  logic miso = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dac_cmd_engine #(.DIV_WR(DIV_WR), .DIV_RD(DIV_RD), .GAP_CYC(GAP_CYC), .LDAC_CYC(LDAC_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_chan_i(req_chan), .req_value_i(req_value), .req_sel_i(req_sel),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .ldac_no(ldac_n)
  );

  // DAC slave model and line monitors
  logic [23:0] frames [32];
  int nfr = 0;
  logic [23:0] shin = '0, tx = '0, reply = 24'h5AC3E1;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_ldac = 1'b1;
  int per_run = 0, last_per = 0, gap_run = 0, last_gap = 0, low_run = 0, last_low = 0;
  int rsp_cnt = 0;
  logic [15:0] rsp_last = '0;

  always @(negedge clk) begin
    if (!cs_n && p_cs) begin
      tx = reply; last_gap = gap_run; gap_run = 0;
    end
    if (cs_n) gap_run++;
    if (sclk && !p_sclk) begin
      miso = tx[23]; tx = {tx[22:0], 1'b0};
      last_per = per_run; per_run = 1;
    end else per_run++;
    if (!sclk && p_sclk) shin = {shin[22:0], mosi};
    if (cs_n && !p_cs) begin
      if (nfr < 32) frames[nfr] = shin;
      nfr++;
    end
    if (!ldac_n) low_run++;
    if (ldac_n && !p_ldac) begin last_low = low_run; low_run = 0; end
    if (rsp_valid) begin rsp_cnt++; rsp_last = rsp_data; end
    p_sclk = sclk; p_cs = cs_n; p_ldac = ldac_n;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [2:0] op, logic [5:0] ch, logic [15:0] val, logic [2:0] sel);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_chan = ch; req_value = val; req_sel = sel; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [8:0] sel_code(logic [2:0] s);
    logic [8:0] t [8] = '{9'h008, 9'h048, 9'h088, 9'h0C8, 9'h101, 9'h102, 9'h103, 9'h106};
    return t[s];
  endfunction

  task automatic t_reset();
    chk("R12 cs_no", cs_n, 1); chk("R12 sclk_o", sclk, 0); chk("R12 ldac_no", ldac_n, 1);
    chk("R12 ready", req_ready, 1); chk("R12 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_chan_writes();
    int n0 = nfr;
    send(3'd0, 6'd3, 16'h1234, 3'd0);
    chk("R2 data frame", frames[n0], {2'b11, 6'd11, 16'h1234});
    chk("R7 write sclk period", last_per, DIV_WR);
    send(3'd1, 6'd0, 16'h8000, 3'd0);
    chk("R2 offset frame", frames[n0+1], {2'b10, 6'd8, 16'h8000});
    send(3'd2, 6'd39, 16'hFFFF, 3'd0);
    chk("R2 gain frame", frames[n0+2], {2'b01, 6'd47, 16'hFFFF});
    chk("R1 one frame per write", nfr - n0, 3);
  endtask

  task automatic t_special();
    int n0 = nfr;
    send(3'd3, 6'd1, 16'h0002, 3'd0);
    chk("R3 control frame", frames[n0], {2'b00, 6'd1, 16'h0002});
    send(3'd3, 6'd11, 16'hA5A5, 3'd0);
    chk("R3 block select frame", frames[n0+1], {2'b00, 6'd11, 16'hA5A5});
  endtask

  task automatic t_ofs_both();
    int n0 = nfr, l0 = last_low;
    send(3'd4, 6'd0, 16'hFFFF, 3'd0);
    chk("R4 two frames", nfr - n0, 2);
    chk("R4 first offset dac", frames[n0], {2'b00, 6'd2, 16'h3FFF});
    chk("R4 second offset dac", frames[n0+1], {2'b00, 6'd3, 16'h3FFF});
    chk("R4 no load pulse", last_low, l0);
  endtask

  task automatic t_read(logic [2:0] sel, logic [5:0] ch, logic [23:0] rep);
    int n0 = nfr, r0 = rsp_cnt;
    logic [15:0] fld;
    reply = rep;
    fld = (16'(sel_code(sel)) + 16'(ch)) << 7;
    send(3'd5, ch, 16'h0, sel);
    chk("R5 read frames", nfr - n0, 2);
    chk("R5 request frame", frames[n0], {2'b00, 6'd5, fld});
    chk("R5 nop frame", frames[n0+1], 24'h0);
    chk("R6 gap at least GAP_CYC", 32'(last_gap >= GAP_CYC), 1);
    chk("R7 read sclk period", last_per, DIV_RD);
    chk("R8 one response cycle", rsp_cnt - r0, 1);
    chk("R8 response data", rsp_last, rep[15:0]);
  endtask

  task automatic t_load();
    int n0 = nfr;
    send(3'd6, 6'd0, 16'h0, 3'd0);
    chk("R9 ldac low width", last_low, LDAC_CYC);
    chk("R9 no frame", nfr - n0, 0);
  endtask

  task automatic t_busy_block();
    int n0 = nfr;
    @(negedge clk);
    req_op = 3'd0; req_chan = 6'd5; req_value = 16'h0F0F; req_valid = 1'b1;
    @(negedge clk);
    req_value = 16'h7777;
    chk("R10 ready low after accept", req_ready, 0);
    repeat (20) @(negedge clk);
    chk("R10 ready low mid frame", req_ready, 0);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10 single frame", nfr - n0, 1);
    chk("R10 first value kept", frames[n0], {2'b11, 6'd13, 16'h0F0F});
  endtask

  task automatic t_rsvd();
    int n0 = nfr, l0 = last_low;
    send(3'd7, 6'd2, 16'h1111, 3'd0);
    chk("R11 no frame", nfr - n0, 0);
    chk("R11 no load pulse", last_low, l0);
    chk("R11 ldac high", ldac_n, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_chan_writes();
    t_special();
    t_ofs_both();
    t_read(3'd4, 6'd0, 24'h5AC3E1);
    t_read(3'd0, 6'd3, 24'h00BEEF);
    t_read(3'd7, 6'd20, 24'hFF8001);
    t_load();
    t_busy_block();
    t_rsvd();
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule